// File: doc/BRIEF.md
# Paged Write Buffer and Programming Sequencer

This block is a synchronous model of the write side of a byte-wide paged nonvolatile memory. A host drives a clocked bus with active-low select, output-enable and write-enable strobes. Each completed write strobe loads one byte into a page buffer of 128 entries. Every byte in one load window belongs to the page named by the first byte. A byte from another page is dropped. When no byte has been accepted for `LOAD_TO` cycles, the window closes and a programming period of `PROG_CYC` cycles starts. At the end of that period, only the buffer entries that were loaded are written into the array. All other bytes of the page keep their old values.

While programming runs, `busy` is high, writes are dropped, and reads return a status byte instead of array data. Software has two ways to detect the end of the write from that status byte. Bit 7 reads as the complement of bit 7 of the last byte loaded. Bit 6 changes value on every read. An external detector supplies `unlock_ok`, which is sampled with the first byte of a window. If it is low at that point, the programming period still runs but nothing is written into the array.

The array size is set by `ADDR_W`. The low 7 address bits select the byte within a page and the upper bits select the page. The full-size part uses `ADDR_W = 17`. The default of 11 keeps elaboration small.

Top module: `pgw_top`

## Requirements
- R1: After reset, `busy` is 0 and `rdata` is 0x00.
- R2: A write strobe is active only while `sel_n`=0, `we_n`=0 and `oe_n`=1. Strobes with `oe_n` low or `sel_n` high load nothing. They start no programming and change no array byte.
- R3: The address is taken in the cycle the write strobe becomes active. The data is the `wdata` value seen in the last cycle the strobe is active. The byte is loaded when the strobe ends.
- R4: Within a window, offsets may be loaded in any order, and reloading an offset replaces its value. After programming, each loaded offset holds its latest value.
- R5: Only offsets loaded in the window are written to the array. The other bytes of that page keep their contents.
- R6: The page (`addr[ADDR_W-1:7]`) of the first byte fixes the window's page. Later bytes that name another page are discarded.
- R7: The window closes after `LOAD_TO` consecutive cycles without an accepted byte. A byte accepted in the very cycle the count would expire wins and keeps the window open. A byte that ends one cycle later is dropped.
- R8: `busy` stays high for exactly `PROG_CYC` cycles. The array is updated as `busy` falls.
- R9: A read that starts while `busy` is high returns a status byte:
  - bit 7 is the inverse of bit 7 of the last accepted byte;
  - bit 6 is 0 on the first such read of a programming period and flips on each later read;
  - bits 5..0 are 0.
  Once `busy` is low, reads return true array data.
- R10: A write whose strobe ends while `busy` is high is ignored. It changes no array byte and opens no new window.
- R11: If `unlock_ok` is 0 when a window's first byte is accepted, the programming period still runs but no array byte changes.
- R12: A read strobe (`sel_n`=0, `oe_n`=0, `we_n`=1) updates `rdata` once, in the cycle it begins, using the address present then. `rdata` holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low device select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address: page in the upper bits, offset in bits 6..0 |
| wdata | input | 8 | Write data |
| unlock_ok | input | 1 | Write unlock valid, sampled with the first byte of a window |
| rdata | output | 8 | Registered read data or status byte |
| busy | output | 1 | High during the programming period |

## Verification
The timeout expiry and a new byte load can fall in the same cycle. The bench provokes this by ending a second write strobe exactly `LOAD_TO` cycles after the first load, and then one cycle later. In the first case `busy` must still be low afterwards and both bytes must reach the array. In the second case programming must already have started, and the late byte must be missing from the array. A second collision is a write strobe that ends while the window closes or programming runs. It is judged by reading back the target byte after `busy` falls and by checking that no further programming period starts.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int DATA_W     = 8;
    localparam int OFS_W      = 7;
    localparam int PAGE_BYTES = 1 << OFS_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;

    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        logic [DATA_W-1:0] data;
    } byte_ld_t;

    function automatic logic [DATA_W-1:0] status_byte(input logic last_b7, input logic tog);
        return {~last_b7, tog, {(DATA_W-2){1'b0}}};
    endfunction
endpackage

// File: rtl/pgw_bus_decode.sv
module pgw_bus_decode
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              block,
    output logic              ld_valid,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data,
    output logic              rd_start
);
    logic wr_act, rd_act, wr_q, rd_q, strobe_ok;

    assign wr_act = !sel_n && !we_n && oe_n;
    assign rd_act = !sel_n && !oe_n && we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q      <= 1'b0;
            rd_q      <= 1'b0;
            strobe_ok <= 1'b0;
            ld_addr   <= '0;
            ld_data   <= '0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            if (wr_act && !wr_q) begin
                ld_addr   <= addr;
                strobe_ok <= !block;
            end
            if (wr_act) ld_data <= wdata;
        end
    end

    assign ld_valid = wr_q && !wr_act && strobe_ok && !block;
    assign rd_start = rd_act && !rd_q;

    // R3: a strobe yields one load pulse only
    p_single_load_r3: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> !ld_valid);
endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              ld_en,
    input  byte_ld_t          ld,
    output logic [DATA_W-1:0] buf_q [PAGE_BYTES],
    output logic [PAGE_BYTES-1:0] mask
);
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mask[i]  <= 1'b0;
                buf_q[i] <= '0;
            end else if (ld_en && ld.ofs == OFS_W'(i)) begin
                mask[i]  <= 1'b1;
                buf_q[i] <= ld.data;
            end else if (clear) begin
                mask[i]  <= 1'b0;
            end
        end
    end

    // R5: commit leaves no stale loaded marks for the next window
    p_mask_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clear && !ld_en) |=> (mask == '0));
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
    import pgw_pkg::*;
#(
    parameter int PAGE_W   = 4,
    parameter int LOAD_TO  = 16,
    parameter int PROG_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [PAGE_W-1:0] ld_page,
    input  logic              unlock_ok,
    output logic              accept,
    output phase_e            phase,
    output logic              commit,
    output logic [PAGE_W-1:0] page_q,
    output logic              armed
);
    localparam int CNT_MAX = (LOAD_TO > PROG_CYC) ? LOAD_TO : PROG_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt;

    assign accept = ld_valid &&
                    ((phase == PH_IDLE) || (phase == PH_LOAD && ld_page == page_q));
    assign commit = (phase == PH_PROG) && (cnt == CNT_W'(PROG_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            page_q <= '0;
            armed  <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (accept) begin
                    phase  <= PH_LOAD;
                    page_q <= ld_page;
                    armed  <= unlock_ok;
                    cnt    <= '0;
                end
                PH_LOAD: begin
                    if (accept) cnt <= '0;
                    else if (cnt == CNT_W'(LOAD_TO - 1)) begin
                        phase <= PH_PROG;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_PROG: begin
                    if (commit) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R7: programming only follows a load window
    p_prog_from_load_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_PROG) |-> ($past(phase) == PH_LOAD));
    // R8: programming ends only after its full count
    p_prog_len_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(phase == PH_PROG) |-> ($past(cnt) == CNT_W'(PROG_CYC - 1)));
endmodule

// File: rtl/pgw_top.sv
module pgw_top
    import pgw_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int LOAD_TO  = 16,
    parameter int PROG_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              unlock_ok,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              ld_valid, rd_start, accept, commit, armed, last_b7, tog;
    logic [ADDR_W-1:0] ld_addr;
    logic [DATA_W-1:0] ld_data;
    logic [PAGE_W-1:0] page_q;
    phase_e            phase;
    byte_ld_t          ld;
    logic [DATA_W-1:0] buf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask;
    logic [DATA_W-1:0] mem [DEPTH];

    assign busy = (phase == PH_PROG);
    assign ld   = '{ofs: ld_addr[OFS_W-1:0], data: ld_data};

    pgw_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst(rst), .sel_n(sel_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .block(busy),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data), .rd_start(rd_start)
    );

    pgw_seq #(.PAGE_W(PAGE_W), .LOAD_TO(LOAD_TO), .PROG_CYC(PROG_CYC)) u_seq (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_page(ld_addr[ADDR_W-1:OFS_W]),
        .unlock_ok(unlock_ok), .accept(accept), .phase(phase), .commit(commit),
        .page_q(page_q), .armed(armed)
    );

    pgw_page_buf u_buf (
        .clk(clk), .rst(rst), .clear(commit), .ld_en(accept), .ld(ld),
        .buf_q(buf_q), .mask(mask)
    );

    always_ff @(posedge clk) begin
        if (commit && armed) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mask[i]) mem[{page_q, OFS_W'(i)}] <= buf_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            last_b7 <= 1'b0;
            tog     <= 1'b0;
        end else begin
            if (accept) last_b7 <= ld_data[DATA_W-1];
            if (!busy) tog <= 1'b0;
            else if (rd_start) tog <= ~tog;
            if (rd_start) rdata <= busy ? status_byte(last_b7, tog) : mem[addr];
        end
    end

    // R10: no byte is loaded while programming runs
    p_no_load_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ld_valid);
    // R12: read data only moves when a read begins
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !rd_start |=> $stable(rdata));
    // R6: the window page stays fixed while loading
    p_page_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && $past(phase) == PH_LOAD) |-> $stable(page_q));
endmodule

// File: tb/pgw_top_bench.sv
module pgw_top_bench;
    localparam int AW  = 11;
    localparam int LTO = 12;
    localparam int PC  = 40;

    logic clk = 1'b0;
    logic rst, sel_n, oe_n, we_n, unlock_ok, busy;
    logic [AW-1:0] addr;
    logic [7:0] wdata, rdata;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pgw_top #(.ADDR_W(AW), .LOAD_TO(LTO), .PROG_CYC(PC)) u_pgw_top (
        .clk(clk), .rst(rst), .sel_n(sel_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .unlock_ok(unlock_ok), .rdata(rdata), .busy(busy)
    );

    function automatic logic [AW-1:0] pa(input int page, input int ofs);
        return {4'(page), 7'(ofs)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk) addr = a; sel_n = 0; oe_n = 1; we_n = 1;
        @(negedge clk) we_n = 0; wdata = d;
        @(negedge clk);
        @(negedge clk) we_n = 1;
        @(negedge clk) sel_n = 1;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk) addr = a; sel_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk) d = rdata;
        @(negedge clk) sel_n = 1; oe_n = 1;
    endtask

    task automatic wait_busy();
        for (int i = 0; i < LTO + 20 && busy !== 1'b1; i++) @(negedge clk);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy === 1'b1 && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_prog();
        int n;
        wait_busy();
        count_busy(n);
    endtask

    task automatic expect_byte(input string req, input logic [AW-1:0] a, input logic [7:0] e);
        logic [7:0] d;
        bus_read(a, d);
        check(req, d, e);
    endtask

    task automatic t_reset();
        check("R1 busy after reset", busy, 0);
        check("R1 rdata after reset", rdata, 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] d;
        bus_write(pa(2, 5), 8'h11);
        bus_write(pa(2, 3), 8'h22);
        bus_write(pa(2, 21), 8'h21);
        bus_write(pa(2, 5), 8'hA5);
        bus_write(pa(2, 9), 8'h3C);
        repeat (LTO - 3) @(negedge clk);
        check("R7 window still open before timeout", busy, 0);
        wait_busy();
        check("R7 programming starts after timeout", busy, 1);
        bus_read(pa(2, 9), d);
        check("R9 first status read", d, 8'h80);
        bus_read(pa(2, 9), d);
        check("R9 second status read toggles bit6", d, 8'hC0);
        repeat (3) @(negedge clk);
        check("R12 rdata holds between reads", rdata, 8'hC0);
        finish_prog();
        expect_byte("R4 reloaded offset holds latest", pa(2, 5), 8'hA5);
        expect_byte("R4 out-of-order offset", pa(2, 3), 8'h22);
        expect_byte("R9 true data after busy", pa(2, 9), 8'h3C);
    endtask

    task automatic t_select();
        bus_write(pa(2, 3), 8'h33);
        finish_prog();
        expect_byte("R5 loaded offset updated", pa(2, 3), 8'h33);
        expect_byte("R5 unloaded offset untouched", pa(2, 5), 8'hA5);
        expect_byte("R5 unloaded offset untouched 2", pa(2, 21), 8'h21);
    endtask

    task automatic t_capture();
        int n;
        @(negedge clk) addr = pa(2, 20); sel_n = 0; oe_n = 1; we_n = 1;
        @(negedge clk) we_n = 0; wdata = 8'h10;
        @(negedge clk) addr = pa(2, 21); wdata = 8'h20;
        @(negedge clk) wdata = 8'h30;
        @(negedge clk) we_n = 1; wdata = 8'hFF;
        @(negedge clk) sel_n = 1;
        wait_busy();
        count_busy(n);
        check("R8 busy length", n, PC);
        expect_byte("R3 address from strobe start, data from last active cycle", pa(2, 20), 8'h30);
        expect_byte("R3 later address ignored", pa(2, 21), 8'h21);
    endtask

    task automatic t_page();
        bus_write(pa(4, 0), 8'h44);
        finish_prog();
        bus_write(pa(3, 0), 8'h33);
        bus_write(pa(4, 0), 8'h99);
        finish_prog();
        expect_byte("R6 first page programmed", pa(3, 0), 8'h33);
        expect_byte("R6 other page byte dropped", pa(4, 0), 8'h44);
    endtask

    task automatic t_boundary(input int late, input logic [7:0] d1, input logic [7:0] d2);
        @(negedge clk) addr = pa(6, 1); sel_n = 0; oe_n = 1; we_n = 1;
        @(negedge clk) we_n = 0; wdata = d1;
        @(negedge clk);
        @(negedge clk) we_n = 1;
        @(negedge clk) sel_n = 1;
        @(negedge clk) addr = pa(6, 2); sel_n = 0;
        @(negedge clk) we_n = 0; wdata = d2;
        repeat (LTO - 3 + late) @(negedge clk);
        we_n = 1;
        @(negedge clk) sel_n = 1;
        check(late == 0 ? "R7 load on expiry cycle wins" : "R7 late load after expiry",
              busy, late == 0 ? 0 : 1);
        finish_prog();
    endtask

    task automatic t_busy_write();
        bus_write(pa(5, 0), 8'h55);
        wait_busy();
        bus_write(pa(5, 0), 8'hEE);
        finish_prog();
        expect_byte("R10 write during busy ignored", pa(5, 0), 8'h55);
        repeat (LTO + 5) @(negedge clk);
        check("R10 no new window from dropped write", busy, 0);
    endtask

    task automatic t_unlock();
        unlock_ok = 0;
        bus_write(pa(2, 3), 8'hFF);
        unlock_ok = 1;
        wait_busy();
        check("R11 programming runs while locked", busy, 1);
        finish_prog();
        expect_byte("R11 locked window writes nothing", pa(2, 3), 8'h33);
    endtask

    task automatic t_inhibit();
        @(negedge clk) addr = pa(2, 3); sel_n = 0; oe_n = 0; we_n = 1; wdata = 8'h01;
        @(negedge clk) we_n = 0;
        repeat (2) @(negedge clk);
        we_n = 1; oe_n = 1;
        @(negedge clk) sel_n = 1;
        @(negedge clk) we_n = 0; wdata = 8'h02;
        repeat (2) @(negedge clk);
        we_n = 1;
        repeat (LTO + 5) @(negedge clk);
        check("R2 inhibited strobes start nothing", busy, 0);
        expect_byte("R2 inhibited strobes change nothing", pa(2, 3), 8'h33);
    endtask

    initial begin
        rst = 1; sel_n = 1; oe_n = 1; we_n = 1; unlock_ok = 1; addr = '0; wdata = '0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_select();
        t_capture();
        t_page();
        t_boundary(0, 8'h61, 8'h62);
        expect_byte("R7 first byte of expiry case", pa(6, 1), 8'h61);
        expect_byte("R7 byte on expiry cycle committed", pa(6, 2), 8'h62);
        t_boundary(1, 8'h71, 8'h72);
        expect_byte("R7 first byte of late case", pa(6, 1), 8'h71);
        expect_byte("R7 late byte not committed", pa(6, 2), 8'h62);
        t_busy_write();
        t_unlock();
        t_inhibit();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule